// File: doc/BRIEF.md
# Mirrored Memory Channel Steering Unit

This unit sits between a cache-line request port and two memory channel command ports, called channel A (index 0) and channel B (index 1). Each cache line is made of an even half and an odd half. With mirroring on, the unit keeps two full copies of every line. The primary copy puts the even half on channel A and the odd half on channel B. The mirror copy crosses the halves over, so each channel holds a complete image of memory. Every channel command carries a copy flag, 0 for the primary location and 1 for the mirror location, together with the line address.

Reads are steered to one copy or the other by a chosen address bit, so the load spreads over both sets of storage. The returned halves are then put back in even-then-odd order, whichever copy was read. A per-channel failure input moves the unit to single-channel operation. In that mode writes to the failed channel stop, and a line is read as two plain reads on the surviving channel.

The unit handles one request at a time. The configuration and failure inputs are sampled when a request is accepted. Every request, read or write, gets exactly one response, tagged with its address. On the request and response ports a line is packed with the even half in bits [HALF_W-1:0] and the odd half above it.

Top module: `mirror_steer`

## Requirements
- R1: With mirroring on, a write gives each live channel two write commands. The first has copy flag 0 and carries the even half on A and the odd half on B. The second has copy flag 1 with the halves swapped: the odd half on A, the even half on B.
- R2: With mirroring on and both channels healthy, a read sends one read command to each channel. Both use the copy flag req_addr[SEL_BIT] XOR cfg_sel_invert, where 0 means primary.
- R3: An interleaved read of the primary copy takes the even half from channel A. A read of the mirror copy takes the even half from channel B. In both cases rsp_rdata holds the line as it was written.
- R4: With mirroring off, a write sends one copy-0 command per live channel, and an interleaved read uses copy 0 whatever the address bit and cfg_sel_invert. The mirror location is never written.
- R5: A channel whose chan_fail bit is set at acceptance gets no command for that request. With mirroring on, a write still sends both copies to the surviving channel.
- R6: In single-channel mode a read sends two read commands to the survivor. On A the order is copy 0 then copy 1; on B it is copy 1 then copy 0. The first reply is the even half.
- R7: The survivor is channel B when chan_fail[0] is set (also when both bits are set), and channel A otherwise.
- R8: req_ready is high only while idle. A response appears only after every command of the request has been accepted and every read reply has come back. rsp_valid and its payload hold until rsp_ready. A channel command holds until that channel's ready.
- R9: After reset req_ready=1, rsp_valid=0 and ch_valid=0. Every response gives the request's address on rsp_addr and its direction on rsp_write.
- R10: cfg_mirror_en, cfg_sel_invert and chan_fail are sampled when the request is accepted. Later changes do not affect a request that is already in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_mirror_en | input | 1 | Keep a mirror copy and steer reads by address |
| cfg_sel_invert | input | 1 | Inverts which address-bit value picks the primary copy |
| chan_fail | input | 2 | Per-channel failure flags (bit 0 = A, bit 1 = B) |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Line address |
| req_wdata | input | 2*HALF_W | Write line, even half low |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response taken |
| rsp_write | output | 1 | Response belongs to a write |
| rsp_addr | output | ADDR_W | Address of the request answered |
| rsp_rdata | output | 2*HALF_W | Read line, even half low |
| ch_valid | output | 2 | Per-channel command valid |
| ch_ready | input | 2 | Per-channel command ready |
| ch_write | output | 2 | Per-channel command is a write |
| ch_copy | output | 2 | Per-channel copy flag (0 primary, 1 mirror) |
| ch_addr | output | 2*ADDR_W | Per-channel line address |
| ch_wdata | output | 2*HALF_W | Per-channel half-line write data |
| ch_rvalid | input | 2 | Per-channel read reply valid |
| ch_rdata | input | 2*HALF_W | Per-channel read reply data |

## Verification
Lines are written with mirroring on, each with distinct even and odd halves. Each line is then read back under all four combinations of address bit and invert flag, so a wrong copy choice shows up in the command log and a wrong half order shows up in the data. Reads with one channel failed, and with both failed, separate the two pair orders and the survivor choice. A read of a line written while the other channel was down returns stale zeros, which shows that suppressed writes never reached that channel. A write with mirroring off, read back through the mirror copy, also returns zeros, which shows the mirror location was left alone.

// File: rtl/msu_pkg.sv
// Package: shared types for the mirrored channel steering unit.
// Assumes two channels, index 0 = A and index 1 = B.
package msu_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_RESP = 2'd2
    } msu_state_t;

    localparam int unsigned NUM_CH   = 2;
    localparam logic        COPY_PRI = 1'b0;
    localparam logic        COPY_MIR = 1'b1;
endpackage

// File: rtl/msu_cmd_plan.sv
// Module: works out, for one request, how many commands each channel gets
// and which copy the first one targets. The second command always targets
// the other copy. Purely combinational; the caller registers the result.
module msu_cmd_plan (
    input  logic            is_write,
    input  logic            mirror_en,
    input  logic            sel_bit,
    input  logic            sel_invert,
    input  logic [1:0]      fail,
    output logic [1:0][1:0] cnt,
    output logic [1:0]      first_copy,
    output logic            single,
    output logic            surv,
    output logic            rd_mir
);
    import msu_pkg::*;

    // Mode decode: single-channel when any channel is down, B survives if A is down.
    always_comb begin
        single = |fail;
        surv   = fail[0];
        rd_mir = mirror_en & (sel_bit ^ sel_invert);
    end

    // Per-channel command count and first copy.
    always_comb begin
        logic live;
        for (int c = 0; c < NUM_CH; c++) begin
            live          = !single || (surv == (c == 1));
            cnt[c]        = 2'd0;
            first_copy[c] = COPY_PRI;
            if (live) begin
                if (is_write) begin
                    cnt[c] = mirror_en ? 2'd2 : 2'd1;
                end else if (single) begin
                    cnt[c]        = 2'd2;
                    first_copy[c] = (c == 1) ? COPY_MIR : COPY_PRI;
                end else begin
                    cnt[c]        = 2'd1;
                    first_copy[c] = rd_mir;
                end
            end
        end
    end
endmodule

// File: rtl/msu_chan_seq.sv
// Module: command sequencer for one channel. Loaded once per request, it
// issues up to two commands in order (the second toggles the copy flag)
// and gathers up to two read replies. Assumes replies come in command order.
module msu_chan_seq #(
    parameter int ADDR_W = 16,
    parameter int HALF_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        ld_cnt,
    input  logic              ld_first,
    input  logic              ld_write,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [HALF_W-1:0] ld_wd0,
    input  logic [HALF_W-1:0] ld_wd1,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic              cmd_write,
    output logic              cmd_copy,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [HALF_W-1:0] cmd_wdata,
    input  logic              rd_valid,
    input  logic [HALF_W-1:0] rd_data,
    output logic              done,
    output logic [HALF_W-1:0] slot0,
    output logic [HALF_W-1:0] slot1
);
    logic [1:0]        cnt_q;
    logic [1:0]        issued_q;
    logic [1:0]        got_q;
    logic              first_q;
    logic              write_q;
    logic [ADDR_W-1:0] addr_q;
    logic [HALF_W-1:0] wd0_q;
    logic [HALF_W-1:0] wd1_q;

    // Load the plan on start, then count accepted commands and stored replies.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            issued_q <= '0;
            got_q    <= '0;
            first_q  <= 1'b0;
            write_q  <= 1'b0;
            addr_q   <= '0;
            wd0_q    <= '0;
            wd1_q    <= '0;
            slot0    <= '0;
            slot1    <= '0;
        end else if (start) begin
            cnt_q    <= ld_cnt;
            issued_q <= '0;
            got_q    <= '0;
            first_q  <= ld_first;
            write_q  <= ld_write;
            addr_q   <= ld_addr;
            wd0_q    <= ld_wd0;
            wd1_q    <= ld_wd1;
        end else begin
            if (cmd_valid && cmd_ready) begin
                issued_q <= issued_q + 2'd1;
            end
            if (rd_valid && !write_q && (got_q < cnt_q)) begin
                if (got_q == 2'd0) begin
                    slot0 <= rd_data;
                end else begin
                    slot1 <= rd_data;
                end
                got_q <= got_q + 2'd1;
            end
        end
    end

    // Present the current command and the completion flag.
    always_comb begin
        cmd_valid = issued_q < cnt_q;
        cmd_write = write_q;
        cmd_copy  = first_q ^ issued_q[0];
        cmd_addr  = addr_q;
        cmd_wdata = issued_q[0] ? wd1_q : wd0_q;
        done      = (issued_q == cnt_q) && (write_q || (got_q == cnt_q));
    end
endmodule

// File: rtl/msu_line_merge.sv
// Module: puts the returned halves back into even-then-odd order for the
// interleaved and single-channel read forms. Purely combinational.
module msu_line_merge #(
    parameter int HALF_W = 32
) (
    input  logic                single,
    input  logic                surv,
    input  logic                rd_mir,
    input  logic [HALF_W-1:0]   a0,
    input  logic [HALF_W-1:0]   a1,
    input  logic [HALF_W-1:0]   b0,
    input  logic [HALF_W-1:0]   b1,
    output logic [2*HALF_W-1:0] line
);
    // Choose the even and odd sources by read form.
    always_comb begin
        if (single) begin
            line = surv ? {b1, b0} : {a1, a0};
        end else if (rd_mir) begin
            line = {a0, b0};
        end else begin
            line = {b0, a0};
        end
    end
endmodule

// File: rtl/mirror_steer.sv
// Module: top of the mirrored channel steering unit. Accepts one line
// request at a time, plans the channel commands, runs one sequencer per
// channel and answers with one response per request.
// Assumes channel read replies arrive in command order, one per cycle at most.
module mirror_steer #(
    parameter int ADDR_W  = 16,
    parameter int HALF_W  = 32,
    parameter int SEL_BIT = 15
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_mirror_en,
    input  logic                       cfg_sel_invert,
    input  logic [1:0]                 chan_fail,
    input  logic                       req_valid,
    output logic                       req_ready,
    input  logic                       req_write,
    input  logic [ADDR_W-1:0]          req_addr,
    input  logic [2*HALF_W-1:0]        req_wdata,
    output logic                       rsp_valid,
    input  logic                       rsp_ready,
    output logic                       rsp_write,
    output logic [ADDR_W-1:0]          rsp_addr,
    output logic [2*HALF_W-1:0]        rsp_rdata,
    output logic [1:0]                 ch_valid,
    input  logic [1:0]                 ch_ready,
    output logic [1:0]                 ch_write,
    output logic [1:0]                 ch_copy,
    output logic [1:0][ADDR_W-1:0]     ch_addr,
    output logic [1:0][HALF_W-1:0]     ch_wdata,
    input  logic [1:0]                 ch_rvalid,
    input  logic [1:0][HALF_W-1:0]     ch_rdata
);
    import msu_pkg::*;

    localparam int LINE_W = 2 * HALF_W;

    msu_state_t        state_q;
    logic              accept;
    logic              cap_write;
    logic              cap_mirror;
    logic              cap_single;
    logic              cap_surv;
    logic              cap_rdmir;
    logic [ADDR_W-1:0] cap_addr;
    logic [LINE_W-1:0] rsp_line_q;
    logic [1:0]        live;

    logic [1:0][1:0]        p_cnt;
    logic [1:0]             p_first;
    logic                   p_single;
    logic                   p_surv;
    logic                   p_rdmir;
    logic [1:0]             seq_done;
    logic [1:0][HALF_W-1:0] slot0;
    logic [1:0][HALF_W-1:0] slot1;
    logic [LINE_W-1:0]      merged;
    logic [HALF_W-1:0]      half_even;
    logic [HALF_W-1:0]      half_odd;

    assign accept    = req_valid && (state_q == ST_IDLE);
    assign half_even = req_wdata[HALF_W-1:0];
    assign half_odd  = req_wdata[LINE_W-1:HALF_W];

    msu_cmd_plan u_plan (
        .is_write   (req_write),
        .mirror_en  (cfg_mirror_en),
        .sel_bit    (req_addr[SEL_BIT]),
        .sel_invert (cfg_sel_invert),
        .fail       (chan_fail),
        .cnt        (p_cnt),
        .first_copy (p_first),
        .single     (p_single),
        .surv       (p_surv),
        .rd_mir     (p_rdmir)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        // Primary copy: A even / B odd; mirror copy crosses them over.
        localparam bit IS_A = (g == 0);
        msu_chan_seq #(
            .ADDR_W (ADDR_W),
            .HALF_W (HALF_W)
        ) u_seq (
            .clk       (clk),
            .rst_n     (rst_n),
            .start     (accept),
            .ld_cnt    (p_cnt[g]),
            .ld_first  (p_first[g]),
            .ld_write  (req_write),
            .ld_addr   (req_addr),
            .ld_wd0    (IS_A ? half_even : half_odd),
            .ld_wd1    (IS_A ? half_odd : half_even),
            .cmd_valid (ch_valid[g]),
            .cmd_ready (ch_ready[g]),
            .cmd_write (ch_write[g]),
            .cmd_copy  (ch_copy[g]),
            .cmd_addr  (ch_addr[g]),
            .cmd_wdata (ch_wdata[g]),
            .rd_valid  (ch_rvalid[g]),
            .rd_data   (ch_rdata[g]),
            .done      (seq_done[g]),
            .slot0     (slot0[g]),
            .slot1     (slot1[g])
        );
    end

    msu_line_merge #(
        .HALF_W (HALF_W)
    ) u_merge (
        .single (cap_single),
        .surv   (cap_surv),
        .rd_mir (cap_rdmir),
        .a0     (slot0[0]),
        .a1     (slot1[0]),
        .b0     (slot0[1]),
        .b1     (slot1[1]),
        .line   (merged)
    );

    // Request life cycle: idle, commands in flight, response waiting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            rsp_line_q <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (accept) state_q <= ST_RUN;
                ST_RUN: if (&seq_done) begin
                    state_q    <= ST_RESP;
                    rsp_line_q <= cap_write ? '0 : merged;
                end
                ST_RESP: if (rsp_ready) state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Capture the request's mode and tag at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_write  <= 1'b0;
            cap_mirror <= 1'b0;
            cap_single <= 1'b0;
            cap_surv   <= 1'b0;
            cap_rdmir  <= 1'b0;
            cap_addr   <= '0;
        end else if (accept) begin
            cap_write  <= req_write;
            cap_mirror <= cfg_mirror_en;
            cap_single <= p_single;
            cap_surv   <= p_surv;
            cap_rdmir  <= p_rdmir;
            cap_addr   <= req_addr;
        end
    end

    // Port outputs and the live-channel view for the checker.
    always_comb begin
        req_ready = (state_q == ST_IDLE);
        rsp_valid = (state_q == ST_RESP);
        rsp_write = cap_write;
        rsp_addr  = cap_addr;
        rsp_rdata = rsp_line_q;
        live      = cap_single ? (cap_surv ? 2'b10 : 2'b01) : 2'b11;
    end
endmodule

// File: rtl/msu_checker.sv
// Module: protocol checker for mirror_steer, attached with bind.
module msu_checker #(
    parameter int ADDR_W = 16,
    parameter int HALF_W = 32
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   req_ready,
    input logic                   rsp_valid,
    input logic                   rsp_ready,
    input logic [ADDR_W-1:0]      rsp_addr,
    input logic [2*HALF_W-1:0]    rsp_rdata,
    input logic [1:0]             ch_valid,
    input logic [1:0]             ch_ready,
    input logic [1:0]             ch_write,
    input logic [1:0]             ch_copy,
    input logic                   cap_mirror,
    input logic [1:0]             live
);
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (ch_valid == 2'b00));

    p_rsp_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    p_rsp_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_addr) && $stable(rsp_rdata)));

    p_cmd_hold_a_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_valid[0] && !ch_ready[0]) |=> (ch_valid[0] && $stable(ch_copy[0]) && $stable(ch_write[0])));

    p_cmd_hold_b_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_valid[1] && !ch_ready[1]) |=> (ch_valid[1] && $stable(ch_copy[1]) && $stable(ch_write[1])));

    p_fail_quiet_a_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ch_valid[0] |-> live[0]);

    p_fail_quiet_b_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ch_valid[1] |-> live[1]);

    p_mirror_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|(ch_valid & ch_write & ch_copy)) |-> cap_mirror);
endmodule

bind mirror_steer msu_checker #(
    .ADDR_W (ADDR_W),
    .HALF_W (HALF_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .rsp_ready  (rsp_ready),
    .rsp_addr   (rsp_addr),
    .rsp_rdata  (rsp_rdata),
    .ch_valid   (ch_valid),
    .ch_ready   (ch_ready),
    .ch_write   (ch_write),
    .ch_copy    (ch_copy),
    .cap_mirror (cap_mirror),
    .live       (live)
);

// File: tb/test_mirror_steer.sv
`timescale 1ns/1ps
module test_mirror_steer;
    localparam int ADDR_W  = 16;
    localparam int HALF_W  = 32;
    localparam int SEL_BIT = 15;
    localparam int NV      = 15;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   cfg_mirror_en = 1'b0;
    logic                   cfg_sel_invert = 1'b0;
    logic [1:0]             chan_fail = 2'b00;
    logic                   req_valid = 1'b0;
    logic                   req_ready;
    logic                   req_write = 1'b0;
    logic [ADDR_W-1:0]      req_addr = '0;
    logic [2*HALF_W-1:0]    req_wdata = '0;
    logic                   rsp_valid;
    logic                   rsp_ready = 1'b1;
    logic                   rsp_write;
    logic [ADDR_W-1:0]      rsp_addr;
    logic [2*HALF_W-1:0]    rsp_rdata;
    logic [1:0]             ch_valid;
    logic [1:0]             ch_ready = 2'b11;
    logic [1:0]             ch_write;
    logic [1:0]             ch_copy;
    logic [1:0][ADDR_W-1:0] ch_addr;
    logic [1:0][HALF_W-1:0] ch_wdata;
    logic [1:0]             ch_rvalid;
    logic [1:0][HALF_W-1:0] ch_rdata;

    mirror_steer #(.ADDR_W(ADDR_W), .HALF_W(HALF_W), .SEL_BIT(SEL_BIT)) i_mirror_steer (
        .clk(clk), .rst_n(rst_n), .cfg_mirror_en(cfg_mirror_en), .cfg_sel_invert(cfg_sel_invert),
        .chan_fail(chan_fail), .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_write(rsp_write), .rsp_addr(rsp_addr), .rsp_rdata(rsp_rdata), .ch_valid(ch_valid),
        .ch_ready(ch_ready), .ch_write(ch_write), .ch_copy(ch_copy), .ch_addr(ch_addr),
        .ch_wdata(ch_wdata), .ch_rvalid(ch_rvalid), .ch_rdata(ch_rdata)
    );

    always #10 clk = ~clk;

    int total = 0;
    int bad = 0;
    int wd_cyc = 0;

    // Channel storage model: index {copy, addr[15], addr[3:0]}.
    logic [HALF_W-1:0] mem [2][64];
    int                tot_n [2] = '{0, 0};
    logic              hist_copy [2][64];
    int                cyc = 0;

    function automatic logic [5:0] midx(input logic copy, input logic [15:0] a);
        return {copy, a[15], a[3:0]};
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 64; i++) begin
                mem[0][i] <= '0;
                mem[1][i] <= '0;
            end
            ch_rvalid <= 2'b00;
            ch_rdata  <= '0;
        end else begin
            for (int c = 0; c < 2; c++) begin
                ch_rvalid[c] <= 1'b0;
                if (ch_valid[c] && ch_ready[c]) begin
                    if (ch_write[c]) mem[c][midx(ch_copy[c], ch_addr[c])] <= ch_wdata[c];
                    else begin
                        ch_rvalid[c] <= 1'b1;
                        ch_rdata[c]  <= mem[c][midx(ch_copy[c], ch_addr[c])];
                    end
                end
            end
        end
    end

    // Command log: copy flag of every accepted command per channel.
    always @(posedge clk) begin
        if (rst_n) begin
            for (int c = 0; c < 2; c++) begin
                if (ch_valid[c] && ch_ready[c]) begin
                    hist_copy[c][tot_n[c] % 64] = ch_copy[c];
                    tot_n[c] = tot_n[c] + 1;
                end
            end
        end
    end

    // Channel back-pressure pattern.
    always @(negedge clk) begin
        cyc <= cyc + 1;
        ch_ready[0] <= (cyc % 3) != 0;
        ch_ready[1] <= (cyc % 4) != 1;
    end

    always @(posedge clk) begin
        wd_cyc <= wd_cyc + 1;
        if (wd_cyc > 50000) begin
            $display("FAIL watchdog: actual=%0d expected<=%0d cycles", wd_cyc, 50000);
            $display("test done: total=%0d bad=%0d", total + 1, bad + 1);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    typedef struct packed {
        bit        wr;
        bit        men;
        bit        inv;
        bit [1:0]  fail;
        bit [15:0] addr;
        bit [63:0] data;
        bit [63:0] expl;
        bit [1:0]  na;
        bit [1:0]  nb;
        bit        ca;
        bit        cb;
    } vec_t;

    localparam bit [63:0] D1 = 64'hB1B1_B1B1_A1A1_A1A1;
    localparam bit [63:0] D2 = 64'hB2B2_B2B2_A2A2_A2A2;
    localparam bit [63:0] D3 = 64'hB3B3_B3B3_A3A3_A3A3;
    localparam bit [63:0] D4 = 64'hB4B4_B4B4_A4A4_A4A4;

    localparam vec_t VEC [NV] = '{
        '{1'b1, 1'b1, 1'b0, 2'b00, 16'h0001, D1, 64'h0, 2'd2, 2'd2, 1'b0, 1'b0},
        '{1'b1, 1'b1, 1'b0, 2'b00, 16'h8002, D2, 64'h0, 2'd2, 2'd2, 1'b0, 1'b0},
        '{1'b0, 1'b1, 1'b0, 2'b00, 16'h0001, 64'h0, D1, 2'd1, 2'd1, 1'b0, 1'b0},
        '{1'b0, 1'b1, 1'b0, 2'b00, 16'h8002, 64'h0, D2, 2'd1, 2'd1, 1'b1, 1'b1},
        '{1'b0, 1'b1, 1'b1, 2'b00, 16'h0001, 64'h0, D1, 2'd1, 2'd1, 1'b1, 1'b1},
        '{1'b0, 1'b1, 1'b1, 2'b00, 16'h8002, 64'h0, D2, 2'd1, 2'd1, 1'b0, 1'b0},
        '{1'b0, 1'b0, 1'b1, 2'b00, 16'h8002, 64'h0, D2, 2'd1, 2'd1, 1'b0, 1'b0},
        '{1'b0, 1'b1, 1'b0, 2'b10, 16'h0001, 64'h0, D1, 2'd2, 2'd0, 1'b0, 1'b0},
        '{1'b0, 1'b1, 1'b0, 2'b01, 16'h8002, 64'h0, D2, 2'd0, 2'd2, 1'b0, 1'b1},
        '{1'b1, 1'b1, 1'b0, 2'b10, 16'h0003, D3, 64'h0, 2'd2, 2'd0, 1'b0, 1'b0},
        '{1'b0, 1'b1, 1'b0, 2'b10, 16'h0003, 64'h0, D3, 2'd2, 2'd0, 1'b0, 1'b0},
        '{1'b0, 1'b1, 1'b0, 2'b11, 16'h0003, 64'h0, 64'h0, 2'd0, 2'd2, 1'b0, 1'b1},
        '{1'b1, 1'b0, 1'b0, 2'b00, 16'h0004, D4, 64'h0, 2'd1, 2'd1, 1'b0, 1'b0},
        '{1'b0, 1'b1, 1'b0, 2'b00, 16'h0004, 64'h0, D4, 2'd1, 2'd1, 1'b0, 1'b0},
        '{1'b0, 1'b1, 1'b1, 2'b00, 16'h0004, 64'h0, 64'h0, 2'd1, 2'd1, 1'b1, 1'b1}
    };

    // Tag per vector: kind 0 = command count/copy, kind 1 = returned data.
    function automatic string vtag(input int i, input int kind);
        case (i)
            0, 1:          return "R1";
            2, 3, 4, 5:    return (kind == 0) ? "R2" : "R3";
            6, 12, 13, 14: return "R4";
            7, 8:          return "R6";
            9, 10:         return "R5";
            default:       return "R7";
        endcase
    endfunction

    logic              r_write;
    logic [15:0]       r_addr;
    logic [63:0]       r_line;
    int                n_a;
    int                n_b;
    logic              c_a0, c_a1, c_b0, c_b1;

    task automatic run_req(input bit wr, input logic [15:0] addr, input logic [63:0] data,
                           input bit men, input bit inv, input logic [1:0] fail,
                           input bit flip, input int hold);
        int base_a;
        int base_b;
        int guard;
        logic [63:0] held;
        @(negedge clk);
        base_a = tot_n[0];
        base_b = tot_n[1];
        req_write = wr; req_addr = addr; req_wdata = data;
        cfg_mirror_en = men; cfg_sel_invert = inv; chan_fail = fail;
        rsp_ready = (hold == 0);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (flip) begin
            cfg_sel_invert = ~inv;
            cfg_mirror_en  = ~men;
            chan_fail      = ~fail;
        end
        guard = 0;
        while (!rsp_valid && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        if (hold > 0) begin
            held = rsp_rdata;
            repeat (hold) @(negedge clk);
            // R8: response held while rsp_ready is low, no new request taken
            chk(rsp_valid == 1'b1, "R8", "rsp_valid held", 64'(rsp_valid), 64'd1);
            chk(rsp_rdata == held, "R8", "rsp_rdata stable", rsp_rdata, held);
            chk(req_ready == 1'b0, "R8", "req_ready low while busy", 64'(req_ready), 64'd0);
            rsp_ready = 1'b1;
        end
        r_write = rsp_write;
        r_addr  = rsp_addr;
        r_line  = rsp_rdata;
        n_a = tot_n[0] - base_a;
        n_b = tot_n[1] - base_b;
        c_a0 = hist_copy[0][base_a % 64];
        c_a1 = hist_copy[0][(base_a + 1) % 64];
        c_b0 = hist_copy[1][base_b % 64];
        c_b1 = hist_copy[1][(base_b + 1) % 64];
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R8", "one response per request", 64'(rsp_valid), 64'd0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        chk(req_ready == 1'b1, "R9", "req_ready after reset", 64'(req_ready), 64'd1);
        chk(rsp_valid == 1'b0, "R9", "rsp_valid after reset", 64'(rsp_valid), 64'd0);
        chk(ch_valid == 2'b00, "R9", "ch_valid after reset", 64'(ch_valid), 64'd0);

        for (int i = 0; i < NV; i++) begin
            run_req(VEC[i].wr, VEC[i].addr, VEC[i].data, VEC[i].men, VEC[i].inv,
                    VEC[i].fail, 1'b0, 0);
            chk(r_write == VEC[i].wr, "R9", $sformatf("vec %0d rsp_write", i), 64'(r_write), 64'(VEC[i].wr));
            chk(r_addr == VEC[i].addr, "R9", $sformatf("vec %0d rsp_addr", i), 64'(r_addr), 64'(VEC[i].addr));
            // Counts are read at response time, so R8 ordering is covered too.
            chk(n_a == int'(VEC[i].na), vtag(i, 0), $sformatf("vec %0d commands on A", i), 64'(n_a), 64'(VEC[i].na));
            chk(n_b == int'(VEC[i].nb), vtag(i, 0), $sformatf("vec %0d commands on B", i), 64'(n_b), 64'(VEC[i].nb));
            if (VEC[i].na != 0)
                chk(c_a0 == VEC[i].ca, vtag(i, 0), $sformatf("vec %0d first copy on A", i), 64'(c_a0), 64'(VEC[i].ca));
            if (VEC[i].nb != 0)
                chk(c_b0 == VEC[i].cb, vtag(i, 0), $sformatf("vec %0d first copy on B", i), 64'(c_b0), 64'(VEC[i].cb));
            if (VEC[i].na == 2)
                chk(c_a1 == !VEC[i].ca, vtag(i, 0), $sformatf("vec %0d second copy on A", i), 64'(c_a1), 64'(!VEC[i].ca));
            if (VEC[i].nb == 2)
                chk(c_b1 == !VEC[i].cb, vtag(i, 0), $sformatf("vec %0d second copy on B", i), 64'(c_b1), 64'(!VEC[i].cb));
            if (!VEC[i].wr)
                chk(r_line == VEC[i].expl, vtag(i, 1), $sformatf("vec %0d read line", i), r_line, VEC[i].expl);
        end

        // R1: stored image of line 0x0001, halves crossed in the mirror copy
        chk(mem[0][midx(1'b0, 16'h0001)] == D1[31:0], "R1", "A primary holds even", 64'(mem[0][midx(1'b0, 16'h0001)]), 64'(D1[31:0]));
        chk(mem[1][midx(1'b0, 16'h0001)] == D1[63:32], "R1", "B primary holds odd", 64'(mem[1][midx(1'b0, 16'h0001)]), 64'(D1[63:32]));
        chk(mem[0][midx(1'b1, 16'h0001)] == D1[63:32], "R1", "A mirror holds odd", 64'(mem[0][midx(1'b1, 16'h0001)]), 64'(D1[63:32]));
        chk(mem[1][midx(1'b1, 16'h0001)] == D1[31:0], "R1", "B mirror holds even", 64'(mem[1][midx(1'b1, 16'h0001)]), 64'(D1[31:0]));
        // R5: failed channel B never saw line 0x0003
        chk(mem[1][midx(1'b0, 16'h0003)] == '0, "R5", "B untouched while failed", 64'(mem[1][midx(1'b0, 16'h0003)]), 64'd0);

        // R10: inputs change right after acceptance; request keeps its mode
        run_req(1'b0, 16'h0001, 64'h0, 1'b1, 1'b0, 2'b00, 1'b1, 0);
        chk(n_a == 1 && n_b == 1, "R10", "interleaved despite later fail change", 64'(n_a + n_b), 64'd2);
        chk(c_a0 == 1'b0, "R10", "copy from accepted invert", 64'(c_a0), 64'd0);
        chk(r_line == D1, "R10", "line after input change", r_line, D1);

        // R8: response back-pressure
        run_req(1'b0, 16'h8002, 64'h0, 1'b1, 1'b0, 2'b00, 1'b0, 3);
        chk(r_line == D2, "R8", "line after hold", r_line, D2);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule